// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block turns the two data lines of a low-speed USB link into a stream of bytes. Its clock runs at eight times the bit rate. The lines pass through a two-stage synchronizer. The block then waits for the idle J level and hunts for the falling edge that starts the sync field. It locks once it sees two K bit times in a row. From that point it samples once per bit and undoes the NRZI coding. It drops the bits that the transmitter inserted after a run of six ones, and it packs the data least significant bit first.

Each finished byte goes out on a one-cycle write strobe, with an address that starts at zero for every packet. A single-ended zero (SE0) at any bit slot except the first slot of a byte ends the packet. When the packet ends, the block pulses `pkt_done`. At that pulse, `byte_count` holds the number of bytes stored and `rx_overflow` shows whether the buffer limit stopped the packet early. The block then goes back to waiting for idle. PID, CRC and address checks belong to the logic that reads the buffer.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is asserted, `wr_en`, `wr_addr`, `wr_data`, `pkt_done`, `byte_count` and `rx_overflow` are all zero.
- R2: After reset or after a packet, no search for a packet starts until D- has been seen high (J, which is D+ low and D- high). A K level (D+ high, D- low) held from reset must not start reception.
- R3: Lock needs a J-to-K edge followed, one bit time later, by a second K. If that later bit is J, the block goes back to searching for the next K. A lone K inside idle produces no write and no `pkt_done`.
- R4: Bits are taken from D- at one sample per 8 clocks. A data 1 is a level equal to the previous bit and a data 0 is a change. The level of the last sync bit (K) serves as the first reference. Bytes are assembled least significant bit first.
- R5: A run counter starts at 1 at lock, because the last sync bit decodes to a 1. It goes up on each decoded 1, clears on each decoded 0, and carries across byte boundaries. When the counter reaches 6, the next bit is dropped and the counter clears.
- R6: Each completed byte is driven on `wr_data` with a one-cycle `wr_en`. `wr_addr` is 0 for the first byte of a packet and increases by one for each following byte.
- R7: SE0 (both lines low) at bit position 1 to 7 of a byte ends the packet and discards the partial byte. `pkt_done` is then high for exactly one cycle, with `byte_count` equal to the number of bytes written.
- R8: SE0 at bit position 0 of a byte does not end the packet. That bit is decoded from D- like any other bit.
- R9: With `BUF_BYTES` bytes already written, completing one more byte writes nothing and ends the packet. `pkt_done` pulses, `rx_overflow` is 1 and `byte_count` equals `BUF_BYTES`. A packet of exactly `BUF_BYTES` bytes completes without error.
- R10: After `pkt_done`, the next packet is received normally. Its byte count restarts from zero and its error flag is cleared at lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| wr_en | output | 1 | One-cycle strobe for a received byte |
| wr_addr | output | $clog2(BUF_BYTES) | Buffer address of the byte on `wr_data` |
| wr_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-cycle pulse at the end of a packet |
| byte_count | output | $clog2(BUF_BYTES+1) | Bytes stored in the current or last packet |
| rx_overflow | output | 1 | Last packet was cut off at the buffer limit |

## Verification
Two functions can fall in the same cycle. The completion of a byte beyond the buffer limit is also the moment of the abort decision, and the block must turn that store into an end-of-packet with the error flag. The bench provokes this with packets of exactly `BUF_BYTES` bytes and of `BUF_BYTES`+1 bytes, and it judges the number of stored bytes, the count and the flag. The second case is SE0 arriving at the first bit slot of a byte, where the dribble rule competes with end-of-packet detection. The bench replaces a K bit at a byte boundary with SE0 and expects every byte to arrive intact.

// File: rtl/usbrx_pkg.sv
`timescale 1ns/1ps
package usbrx_pkg;
  localparam int BYTE_W = 8;
  localparam int POS_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_WAIT_J,
    ST_HUNT,
    ST_CHECK,
    ST_RX
  } rx_state_t;
endpackage

// File: rtl/usbrx_linesync.sv
`timescale 1ns/1ps
module usbrx_linesync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_in;
      stab_q <= meta_q;
    end
  end

  assign d_out = stab_q;
endmodule

// File: rtl/usbrx_framer.sv
`timescale 1ns/1ps
module usbrx_framer
  import usbrx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_dp,
  input  logic line_dm,
  input  logic stop,
  output logic bit_stb,
  output logic lock
);
  // the second K is judged one bit plus half a bit after the edge
  localparam int CHK_PT = OVS + OVS/2 - 2;
  localparam int CNTW   = $clog2(CHK_PT + 1);

  rx_state_t       state_q, state_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  assign bit_stb = (state_q == ST_RX) && (cnt_q == CNTW'(OVS - 1));

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    lock    = 1'b0;
    case (state_q)
      ST_WAIT_J: begin
        if (line_dm) state_n = ST_HUNT;
      end
      ST_HUNT: begin
        if (!line_dm) begin
          state_n = ST_CHECK;
          cnt_n   = '0;
        end
      end
      ST_CHECK: begin
        if (cnt_q == CNTW'(CHK_PT)) begin
          cnt_n = '0;
          if (line_dp && !line_dm) begin
            state_n = ST_RX;
            lock    = 1'b1;
          end else begin
            state_n = ST_HUNT;
          end
        end else begin
          cnt_n = cnt_q + CNTW'(1);
        end
      end
      ST_RX: begin
        if (bit_stb) cnt_n = '0;
        else         cnt_n = cnt_q + CNTW'(1);
        if (stop) begin
          state_n = ST_WAIT_J;
          cnt_n   = '0;
        end
      end
      default: state_n = ST_WAIT_J;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_J;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  AST_HUNT_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && $past(state_q) == ST_WAIT_J) |-> $past(line_dm)); // R2
  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R4
endmodule

// File: rtl/usbrx_deser.sv
`timescale 1ns/1ps
module usbrx_deser
  import usbrx_pkg::*;
#(
  parameter int STUFF_LEN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              bit_stb,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              eop
);
  localparam int RW = $clog2(STUFF_LEN + 1);

  logic              prev_dm_q, prev_dm_n;
  logic [RW-1:0]     run_q, run_n;
  logic [POS_W-1:0]  pos_q, pos_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              bit_d;
  logic              se0;

  assign bit_d     = (line_dm == prev_dm_q);
  assign se0       = !line_dp && !line_dm;
  assign byte_data = {bit_d, sh_q[BYTE_W-1:1]};

  always_comb begin
    prev_dm_n = prev_dm_q;
    run_n     = run_q;
    pos_n     = pos_q;
    sh_n      = sh_q;
    byte_vld  = 1'b0;
    eop       = 1'b0;
    if (lock) begin
      prev_dm_n = 1'b0;
      run_n     = RW'(1);
      pos_n     = '0;
      sh_n      = '0;
    end else if (bit_stb) begin
      if (se0 && pos_q != '0) begin
        eop = 1'b1;
      end else begin
        prev_dm_n = line_dm;
        if (run_q == RW'(STUFF_LEN)) begin
          run_n = '0;
        end else begin
          sh_n  = {bit_d, sh_q[BYTE_W-1:1]};
          pos_n = pos_q + POS_W'(1);
          run_n = bit_d ? run_q + RW'(1) : '0;
          if (pos_q == POS_W'(BYTE_W - 1)) byte_vld = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dm_q <= 1'b0;
      run_q     <= '0;
      pos_q     <= '0;
      sh_q      <= '0;
    end else begin
      prev_dm_q <= prev_dm_n;
      run_q     <= run_n;
      pos_q     <= pos_n;
      sh_q      <= sh_n;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(STUFF_LEN)); // R5
endmodule

// File: rtl/usb_ls_rx.sv
`timescale 1ns/1ps
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int OVS       = 8,
  parameter int BUF_BYTES = 8,
  parameter int STUFF_LEN = 6,
  localparam int CW = $clog2(BUF_BYTES + 1),
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_dp,
  input  logic              usb_dm,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              pkt_done,
  output logic [CW-1:0]     byte_count,
  output logic              rx_overflow
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [1:0]        line_s;
  logic              bit_stb, lock, stop;
  logic              byte_vld, eop;
  logic [BYTE_W-1:0] byte_data;

  logic              wr_en_q, wr_en_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [BYTE_W-1:0] data_q, data_n;
  logic              done_q, done_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              err_q, err_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  usbrx_linesync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  ({usb_dp, usb_dm}),
    .d_out (line_s)
  );

  usbrx_framer #(.OVS(OVS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_dp (line_s[1]),
    .line_dm (line_s[0]),
    .stop    (stop),
    .bit_stb (bit_stb),
    .lock    (lock)
  );

  usbrx_deser #(.STUFF_LEN(STUFF_LEN)) u_deser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lock      (lock),
    .bit_stb   (bit_stb),
    .line_dp   (line_s[1]),
    .line_dm   (line_s[0]),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .eop       (eop)
  );

  always_comb begin
    stop    = 1'b0;
    wr_en_n = 1'b0;
    addr_n  = addr_q;
    data_n  = data_q;
    done_n  = 1'b0;
    cnt_n   = cnt_q;
    err_n   = err_q;
    if (lock) begin
      cnt_n = '0;
      err_n = 1'b0;
    end
    if (byte_vld) begin
      if (cnt_q == CW'(BUF_BYTES)) begin
        stop   = 1'b1;
        done_n = 1'b1;
        err_n  = 1'b1;
      end else begin
        wr_en_n = 1'b1;
        addr_n  = AW'(cnt_q);
        data_n  = byte_data;
        cnt_n   = cnt_q + CW'(1);
      end
    end
    if (eop) begin
      stop   = 1'b1;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_en_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      wr_en_q <= wr_en_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      done_q  <= done_n;
      cnt_q   <= cnt_n;
      err_q   <= err_n;
    end
  end

  assign wr_en       = wr_en_q;
  assign wr_addr     = addr_q;
  assign wr_data     = data_q;
  assign pkt_done    = done_q;
  assign byte_count  = cnt_q;
  assign rx_overflow = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    pkt_done |=> !pkt_done); // R7
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    pkt_done |-> !wr_en); // R9
  AST_COUNT_TRACKS_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> byte_count == CW'(wr_addr) + CW'(1)); // R6
  AST_OVERFLOW_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pkt_done && rx_overflow) |-> byte_count == CW'(BUF_BYTES)); // R9
endmodule

// File: tb/sim_usb_ls_rx.sv
`timescale 1ns/1ps
module sim_usb_ls_rx;
  localparam int OVS = 8;
  localparam int BUF = 8;
  localparam int CW  = $clog2(BUF + 1);
  localparam int AW  = $clog2(BUF);

  logic          clk;
  logic          rst_n;
  logic          dp, dm;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          pkt_done;
  logic [CW-1:0] byte_count;
  logic          rx_overflow;

  int n_chk;
  int n_fail;
  int cap_n;
  int done_cnt;
  int last_cnt;
  logic last_err;
  logic [7:0] pkt      [0:15];
  logic [7:0] cap_data [0:31];
  int         cap_addr [0:31];

  usb_ls_rx #(.OVS(OVS), .BUF_BYTES(BUF), .STUFF_LEN(6)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .usb_dp      (dp),
    .usb_dm      (dm),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pkt_done    (pkt_done),
    .byte_count  (byte_count),
    .rx_overflow (rx_overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (cap_n < 32) begin
          cap_data[cap_n] = wr_data;
          cap_addr[cap_n] = int'(wr_addr);
        end
        cap_n++;
      end
      if (pkt_done) begin
        done_cnt++;
        last_cnt = int'(byte_count);
        last_err = rx_overflow;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_n    = 0;
    done_cnt = 0;
    last_cnt = -1;
    last_err = 1'b0;
  endtask

  task automatic put(input logic p, input logic m);
    dp = p;
    dm = m;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic do_reset(input logic p, input logic m);
    rst_n = 1'b0;
    dp    = p;
    dm    = m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // idle, sync, NRZI data with stuffing, optional partial zero bits, EOP
  task automatic send_pkt(input int n, input int partial, input int glitch);
    logic k;
    int   run;
    repeat (4) put(1'b0, 1'b1);
    put(1'b1, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b1);
    put(1'b1, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b0); put(1'b1, 1'b0);
    k   = 1'b1;
    run = 1;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (pkt[i][b]) run++;
        else begin
          k   = ~k;
          run = 0;
        end
        if (i == glitch && b == 0 && k) put(1'b0, 1'b0);
        else                            put(k, ~k);
        if (run == 6) begin
          k   = ~k;
          run = 0;
          put(k, ~k);
        end
      end
    end
    for (int b = 0; b < partial; b++) begin
      k = ~k;
      put(k, ~k);
    end
    put(1'b0, 1'b0);
    put(1'b0, 1'b0);
    repeat (4) put(1'b0, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_pkt(input string req, input int n_exp, input bit err_exp);
    chk(done_cnt == 1, {req, " done pulses"}, done_cnt, 1);
    chk(last_cnt == n_exp, {req, " byte_count"}, last_cnt, n_exp);
    chk(last_err == err_exp, {req, " overflow flag"}, int'(last_err), int'(err_exp));
    chk(cap_n == n_exp, {req, " writes"}, cap_n, n_exp);
    for (int i = 0; i < n_exp && i < cap_n; i++) begin
      chk(cap_data[i] == pkt[i], {req, " data"}, int'(cap_data[i]), int'(pkt[i]));
      chk(cap_addr[i] == i, {req, " R6 address"}, cap_addr[i], i);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    dp    = 1'b0;
    dm    = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && pkt_done == 1'b0, "R1 strobes in reset", int'({wr_en, pkt_done}), 0);
    chk(byte_count == '0 && rx_overflow == 1'b0, "R1 count/flag in reset",
        int'(byte_count) + int'(rx_overflow), 0);
    chk(wr_addr == '0 && wr_data == '0, "R1 addr/data in reset", int'(wr_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic();
    clear_cap();
    pkt[0] = 8'hC3; pkt[1] = 8'h5A; pkt[2] = 8'h01;
    send_pkt(3, 0, -1);
    expect_pkt("R4 R7 basic", 3, 1'b0);
  endtask

  task automatic t_stuff();
    clear_cap();
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
    send_pkt(3, 0, -1);
    expect_pkt("R5 stuffing", 3, 1'b0);
  endtask

  task automatic t_cross();
    clear_cap();
    pkt[0] = 8'hF0; pkt[1] = 8'h03; pkt[2] = 8'h55;
    send_pkt(3, 0, -1);
    expect_pkt("R5 run across bytes", 3, 1'b0);
  endtask

  task automatic t_glitch();
    clear_cap();
    pkt[0] = 8'h00; pkt[1] = 8'h81; pkt[2] = 8'h42;
    send_pkt(3, 0, 1);
    expect_pkt("R8 SE0 at bit 0", 3, 1'b0);
  endtask

  task automatic t_partial();
    clear_cap();
    pkt[0] = 8'h12; pkt[1] = 8'h34;
    send_pkt(2, 3, -1);
    expect_pkt("R7 partial byte", 2, 1'b0);
  endtask

  task automatic t_false_sync();
    clear_cap();
    repeat (4) put(1'b0, 1'b1);
    put(1'b1, 1'b0);
    repeat (20) put(1'b0, 1'b1);
    chk(done_cnt == 0, "R3 lone K done", done_cnt, 0);
    chk(cap_n == 0, "R3 lone K writes", cap_n, 0);
    clear_cap();
    pkt[0] = 8'h3C; pkt[1] = 8'h99;
    send_pkt(2, 0, -1);
    expect_pkt("R3 after false sync", 2, 1'b0);
  endtask

  task automatic t_wait_j();
    do_reset(1'b1, 1'b0);
    clear_cap();
    repeat (12) put(1'b1, 1'b0);
    chk(cap_n == 0 && done_cnt == 0, "R2 K from reset", cap_n + done_cnt, 0);
    clear_cap();
    pkt[0] = 8'hA5;
    send_pkt(1, 0, -1);
    expect_pkt("R2 first packet", 1, 1'b0);
  endtask

  task automatic t_overflow();
    clear_cap();
    for (int i = 0; i <= BUF; i++) pkt[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
    pkt[3] = 8'h26;
    send_pkt(BUF + 1, 0, -1);
    expect_pkt("R9 overflow", BUF, 1'b1);
  endtask

  task automatic t_exact();
    clear_cap();
    for (int i = 0; i < BUF; i++) pkt[i] = 8'h10 + 8'(i);
    send_pkt(BUF, 0, -1);
    expect_pkt("R9 R10 exact fill", BUF, 1'b0);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    clear_cap();
    @(negedge clk);
    t_reset();
    t_basic();
    t_stuff();
    t_cross();
    t_glitch();
    t_partial();
    t_false_sync();
    t_wait_j();
    t_overflow();
    t_exact();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule